// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

A debug block that sits beside a processor's bus and watches one access per cycle. Four breakpoint slots each hold a linear address, and a shared control word gives every slot an enable bit, a length code and an access-type code. When an observed access overlaps a slot's aligned byte window and its kind passes the slot's type filter, the slot hits. The hit vector appears on a registered output one cycle later. The hits are also folded into a sticky status word that software reads and clears.

Software reaches the eight 32-bit debug registers through a simple port: a write strobe with a write index, and a separate read index with a combinational read. Indices 0 to 3 are the slot addresses, 4 and 5 are reserved, 6 is status and 7 is control.

Top module: `bkpt_match_unit`

## Requirements
- R1: Registers 0–3 and 7 read back the last value written to them. Register 6 reads the four slot hit flags in bits 3:0, and its upper bits read as zero.
- R2: Writes to registers 4 and 5 change no register, and reads from 4 and 5 return zero.
- R3: Control bit n (n = 0..3) enables slot n. A slot whose enable bit is 0 never hits.
- R4: The type code of slot n sits in control bits 17+4n:16+4n. Code 00 matches only instruction fetches, 01 only data writes, 10 only I/O accesses, and 11 data reads or data writes, never fetches.
- R5: The length code of slot n sits in control bits 19+4n:18+4n. Code 00 covers 1 byte, 01 covers 2 bytes and 11 covers 4 bytes. The window starts at the slot address with its low bits cleared to that size.
- R6: A slot with length code 10 never hits.
- R7: The access kind is encoded 00 fetch, 01 data write, 10 data read, 11 I/O. The access size code 00 is 1 byte, 01 is 2 bytes, and 10 or 11 is 4 bytes. A slot hits when any byte of the access lies inside its window. Byte addresses are not wrapped past 0xFFFFFFFF.
- R8: hit_vec shows the matches of an access presented with acc_valid high on the next clock cycle. It is all zero after a cycle with acc_valid low.
- R9: Status flags are set by hits and stay set until register 6 is written. A write to register 6 loads bits 3:0 of the data. A hit in the same cycle as that write is still recorded.
- R10: Reset is synchronous and active high. It clears all registers and hit_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Debug register write strobe |
| reg_waddr | input | 3 | Index of the register written |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Index of the register read |
| reg_rdata | output | 32 | Read data, combinational |
| acc_valid | input | 1 | Observed access is present this cycle |
| acc_addr | input | 32 | Linear address of the access |
| acc_size | input | 2 | Access size code |
| acc_kind | input | 2 | Access kind code |
| hit_vec | output | 4 | Registered per-slot hit flags |

## Verification
The hit vector is due one clock after the access cycle, so the bench drives an access on a falling edge and compares hit_vec on the following falling edge. Status flags change on that same edge, and reads are combinational, so the bench checks a status readback in the cycle after the access. A register write takes effect at the rising edge after the strobe, and its readback is checked on the next falling edge. Random accesses around a few breakpoint addresses are scored against a byte-by-byte reference model. Directed cases cover the undefined length, disabled slots, address wrap, and a status write in the same cycle as a hit.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int unsigned NSLOT    = 4;
    localparam int unsigned DW       = 32;
    localparam int unsigned RIDX_W   = 3;
    localparam int unsigned FLD_BASE = 16;
    localparam int unsigned FLD_STEP = 4;
    localparam logic [RIDX_W-1:0] REG_STAT = 3'd6;
    localparam logic [RIDX_W-1:0] REG_CTRL = 3'd7;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_IO    = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_EXEC  = 2'b00,
        FLT_WRITE = 2'b01,
        FLT_IO    = 2'b10,
        FLT_DATA  = 2'b11
    } flt_e;

    typedef struct packed {
        logic          en;
        flt_e          flt;
        logic [1:0]    len;
        logic [DW-1:0] base;
    } slot_cfg_t;

    typedef struct packed {
        logic          valid;
        acc_kind_e     kind;
        logic [1:0]    size;
        logic [DW-1:0] addr;
    } access_t;

    function automatic logic kind_passes(flt_e f, acc_kind_e k);
        case (f)
            FLT_EXEC:  return k == ACC_FETCH;
            FLT_WRITE: return k == ACC_WRITE;
            FLT_IO:    return k == ACC_IO;
            default:   return (k == ACC_WRITE) || (k == ACC_READ);
        endcase
    endfunction

    // Highest byte offset covered by a length code (0, 1 or 3)
    function automatic logic [1:0] len_span(logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] size_span(logic [1:0] code);
        case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
    import bkpt_pkg::*;
(
    input  slot_cfg_t cfg,
    input  access_t   acc,
    output logic      match
);
    logic [1:0]  win_span;
    logic [DW:0] win_lo, win_hi, acc_lo, acc_hi;
    logic        overlap;

    always_comb begin
        win_span = len_span(cfg.len);
        win_lo   = {1'b0, cfg.base & ~{{(DW-2){1'b0}}, win_span}};
        win_hi   = win_lo + {{(DW-1){1'b0}}, win_span};
        acc_lo   = {1'b0, acc.addr};
        acc_hi   = acc_lo + {{(DW-1){1'b0}}, size_span(acc.size)};
        overlap  = (acc_lo <= win_hi) && (win_lo <= acc_hi);
        match    = acc.valid && cfg.en && (cfg.len != 2'b10)
                   && kind_passes(cfg.flt, acc.kind) && overlap;
    end
endmodule

// File: rtl/bkpt_regfile.sv
module bkpt_regfile
    import bkpt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [RIDX_W-1:0]       waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [RIDX_W-1:0]       raddr,
    input  logic [NSLOT-1:0]        hits,
    output logic [DW-1:0]           rdata,
    output slot_cfg_t [NSLOT-1:0]   cfg,
    output logic [NSLOT-1:0]        status
);
    logic [DW-1:0]    base_q [NSLOT];
    logic [DW-1:0]    ctrl_q;
    logic [NSLOT-1:0] stat_q;
    logic             stat_wr;

    assign stat_wr = we && (waddr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) base_q[i] <= '0;
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++)
                if (we && (waddr == RIDX_W'(i))) base_q[i] <= wdata;
            if (we && (waddr == REG_CTRL)) ctrl_q <= wdata;
            stat_q <= (stat_wr ? wdata[NSLOT-1:0] : stat_q) | hits;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_cfg
        assign cfg[g].en   = ctrl_q[g];
        assign cfg[g].flt  = flt_e'(ctrl_q[FLD_BASE+FLD_STEP*g +: 2]);
        assign cfg[g].len  = ctrl_q[FLD_BASE+FLD_STEP*g+2 +: 2];
        assign cfg[g].base = base_q[g];
    end

    assign status = stat_q;

    always_comb begin
        rdata = '0;
        case (raddr)
            3'd0, 3'd1, 3'd2, 3'd3: rdata = base_q[raddr[1:0]];
            REG_STAT:               rdata = {{(DW-NSLOT){1'b0}}, stat_q};
            REG_CTRL:               rdata = ctrl_q;
            default:                rdata = '0;
        endcase
    end

    // R9
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/bkpt_match_unit.sv
module bkpt_match_unit
    import bkpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [2:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    input  logic        acc_valid,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_size,
    input  logic [1:0]  acc_kind,
    output logic [3:0]  hit_vec
);
    slot_cfg_t [NSLOT-1:0] cfg;
    access_t               acc;
    logic [NSLOT-1:0]      match;
    logic [NSLOT-1:0]      status;
    logic [NSLOT-1:0]      hit_q;

    assign acc.valid = acc_valid;
    assign acc.kind  = acc_kind_e'(acc_kind);
    assign acc.size  = acc_size;
    assign acc.addr  = acc_addr;

    bkpt_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .waddr  (reg_waddr),
        .wdata  (reg_wdata),
        .raddr  (reg_raddr),
        .hits   (match),
        .rdata  (reg_rdata),
        .cfg    (cfg),
        .status (status)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        bkpt_slot_cmp u_cmp (
            .cfg   (cfg[g]),
            .acc   (acc),
            .match (match[g])
        );

        // R6
        undef_len_chk: assert property (@(posedge clk) disable iff (rst)
            (acc_valid && cfg[g].len == 2'b10) |=> !hit_q[g]);

        // R3
        disabled_slot_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg[g].en |=> !hit_q[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= '0;
        else     hit_q <= match;
    end

    assign hit_vec = hit_q;

    // R8
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (hit_vec == '0));

    // R9
    hit_in_status_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_vec & ~status) == '0);

    // R2
    reserved_read_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_raddr == 3'd4 || reg_raddr == 3'd5) |-> reg_rdata == '0);
endmodule

// File: tb/bkpt_match_unit_tb.sv
module bkpt_match_unit_tb;
    logic        clk = 0;
    logic        rst;
    logic        reg_we = 0;
    logic [2:0]  reg_waddr = 0;
    logic [31:0] reg_wdata = 0;
    logic [2:0]  reg_raddr = 0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 0;
    logic [31:0] acc_addr = 0;
    logic [1:0]  acc_size = 0;
    logic [1:0]  acc_kind = 0;
    logic [3:0]  hit_vec;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [31:0] m_reg [8];
    logic [3:0]  m_stat;

    always #2 clk = ~clk;

    bkpt_match_unit u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_kind(acc_kind), .hit_vec(hit_vec)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit slot_hits(int s, logic [31:0] a, logic [1:0] sz, logic [1:0] k);
        logic [31:0] c = m_reg[7];
        logic [1:0]  ty = c[16+4*s +: 2];
        logic [1:0]  ln = c[18+4*s +: 2];
        longint nb, na, base;
        bit kok;
        if (!c[s]) return 0;
        if (ln == 2'b10) return 0;
        nb = (ln == 2'b00) ? 1 : (ln == 2'b01) ? 2 : 4;
        na = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        case (ty)
            2'b00: kok = (k == 2'b00);
            2'b01: kok = (k == 2'b01);
            2'b10: kok = (k == 2'b11);
            default: kok = (k == 2'b01) || (k == 2'b10);
        endcase
        if (!kok) return 0;
        base = longint'(m_reg[s]) - (longint'(m_reg[s]) % nb);
        for (longint i = 0; i < na; i++)
            if ((longint'(a) + i) >= base && (longint'(a) + i) < base + nb) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] exp_hits(logic [31:0] a, logic [1:0] sz, logic [1:0] k);
        logic [3:0] v = '0;
        for (int s = 0; s < 4; s++) v[s] = slot_hits(s, a, sz, k);
        return v;
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        if (a == 3'd6) m_stat = d[3:0];
        else if (a != 3'd4 && a != 3'd5) m_reg[a] = d;
    endtask

    task automatic reg_chk(input logic [2:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        reg_raddr = a;
        #1;
        if (a == 3'd6) e = {28'b0, m_stat};
        else if (a == 3'd4 || a == 3'd5) e = 0;
        else e = m_reg[a];
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k, input string req);
        logic [3:0] e;
        @(negedge clk);
        acc_valid = 1; acc_addr = a; acc_size = sz; acc_kind = k;
        e = exp_hits(a, sz, k);
        @(negedge clk);
        acc_valid = 0;
        chk(hit_vec == e, req, {28'b0, hit_vec}, {28'b0, e});
        m_stat = m_stat | e;
    endtask

    // fields: slot s enable, type ty, length ln
    function automatic logic [31:0] ctl(logic [3:0] en, logic [1:0] ty [4], logic [1:0] ln [4]);
        logic [31:0] c = {28'b0, en};
        for (int s = 0; s < 4; s++) begin
            c[16+4*s +: 2] = ty[s];
            c[18+4*s +: 2] = ln[s];
        end
        return c;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] ty [4];
        logic [1:0] ln [4];
        logic [3:0] e;
        void'($urandom(32'd1357));
        for (int i = 0; i < 8; i++) m_reg[i] = 0;
        m_stat = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R10 reset state
        for (int i = 0; i < 8; i++) reg_chk(3'(i), "R10 reset reg");
        chk(hit_vec == 0, "R10 reset hit_vec", {28'b0, hit_vec}, 0);

        // R1 readback
        for (int i = 0; i < 4; i++) begin
            reg_wr(3'(i), $urandom);
            reg_chk(3'(i), "R1 addr readback");
        end
        reg_wr(3'd7, 32'hA5A5_F00F);
        reg_chk(3'd7, "R1 ctrl readback");
        reg_wr(3'd6, 32'hFFFF_FFFA);
        reg_chk(3'd6, "R1 status readback");
        reg_wr(3'd6, 0);

        // R2 reserved
        reg_wr(3'd4, 32'hDEAD_BEEF);
        reg_wr(3'd5, 32'h1234_5678);
        for (int i = 0; i < 8; i++) reg_chk(3'(i), "R2 reserved ignored");

        // R4/R5 directed: slot0 exec 1B, slot1 write 2B, slot2 io 4B, slot3 data 4B
        ty = '{2'b00, 2'b01, 2'b10, 2'b11};
        ln = '{2'b00, 2'b01, 2'b11, 2'b11};
        reg_wr(0, 32'h0000_1000);
        reg_wr(1, 32'h0000_2003);
        reg_wr(2, 32'h0000_3006);
        reg_wr(3, 32'h0000_4001);
        reg_wr(7, ctl(4'hF, ty, ln));
        access(32'h1000, 2'b00, 2'b00, "R4 exec hit");
        access(32'h1000, 2'b00, 2'b10, "R4 exec ignores read");
        access(32'h2002, 2'b00, 2'b01, "R5 2-byte aligned window");
        access(32'h2004, 2'b00, 2'b01, "R5 outside window");
        access(32'h3004, 2'b00, 2'b11, "R4 io hit");
        access(32'h3004, 2'b00, 2'b10, "R4 io ignores read");
        access(32'h4003, 2'b00, 2'b10, "R4 data read hit");
        access(32'h4000, 2'b00, 2'b00, "R4 data ignores fetch");
        access(32'h0FFF, 2'b01, 2'b00, "R7 2-byte access overlap");
        access(32'h0FFC, 2'b11, 2'b00, "R7 4-byte access miss");
        reg_chk(3'd6, "R9 sticky status");

        // R8: idle cycle clears hit_vec
        @(negedge clk);
        chk(hit_vec == 0, "R8 idle clears", {28'b0, hit_vec}, 0);

        // R9: status write with simultaneous hit
        @(negedge clk);
        reg_we = 1; reg_waddr = 3'd6; reg_wdata = 0;
        acc_valid = 1; acc_addr = 32'h1000; acc_size = 0; acc_kind = 0;
        e = exp_hits(32'h1000, 0, 0);
        @(negedge clk);
        reg_we = 0; acc_valid = 0;
        m_stat = e;
        reg_chk(3'd6, "R9 write plus hit");

        // R6 undefined length, R3 disable
        ln = '{2'b10, 2'b01, 2'b11, 2'b11};
        reg_wr(7, ctl(4'hF, ty, ln));
        access(32'h1000, 2'b00, 2'b00, "R6 undefined length");
        reg_wr(7, ctl(4'h0, ty, ln));
        access(32'h3004, 2'b00, 2'b11, "R3 disabled slot");
        reg_chk(3'd6, "R3 status unchanged");

        // R7 top of address space
        ty = '{2'b11, 2'b11, 2'b11, 2'b11};
        ln = '{2'b11, 2'b11, 2'b11, 2'b11};
        reg_wr(0, 32'hFFFF_FFFD);
        reg_wr(1, 32'h0000_0000);
        reg_wr(7, ctl(4'h3, ty, ln));
        access(32'hFFFF_FFFF, 2'b11, 2'b01, "R7 no wrap at top");

        // random mix
        for (int n = 0; n < 400; n++) begin
            if (n % 40 == 0) begin
                for (int s = 0; s < 4; s++) begin
                    ty[s] = 2'($urandom);
                    ln[s] = 2'($urandom);
                    reg_wr(3'(s), 32'h5000 + ($urandom % 16));
                end
                reg_wr(7, ctl(4'($urandom), ty, ln));
                reg_wr(6, 0);
            end
            access(32'h4FFE + ($urandom % 20), 2'($urandom), 2'($urandom), "R7 random access");
            if (n % 25 == 0) reg_chk(3'd6, "R9 random status");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule